// File: doc/BRIEF.md
# Legacy Memory Region Router

This block steers memory requests that fall in the PC legacy window between 0xA0000 and 0xFFFFF. Thirteen shadow segments and one system-management RAM window each have a routing rule. These rules live in eight byte-wide configuration registers behind a small write/read port. For each request, given as an address, a write flag and a system-management-mode flag, the block returns one route code. The code says whether the access is served by main DRAM, forwarded to the PCI side, dropped, or lies outside the legacy window.

The shadow segments are not all the same size. The top 64 KiB (0xF0000–0xFFFFF) is segment 0. Twelve 16 KiB segments, numbered 1 to 12, run upward from 0xC0000. Each segment reads a 2-bit attribute from half of an attribute register. The 128 KiB window at 0xA0000 is backed by DRAM only while the management window is open, or while the request runs in management mode with the global enable set. By default the route is registered, so the response arrives one cycle after the request. A parameter selects a purely combinational variant instead.

Top module: `lmr_router`

## Requirements
- R1: After reset all seven attribute registers read 0x00, the management control register reads 0x02, `rsp_valid` is low, and every request in the legacy window routes to PCI (code 1), whatever its write and mode flags.
- R2: Addresses 0xF0000–0xFFFFF select segment 0. Address 0xC0000 + k·0x4000 through 0xC3FFF + k·0x4000 selects segment k+1, for k from 0 to 11.
- R3: Segment s reads attribute register (s+1)/2, rounded down, at configuration address 0–6. Even segments use bits 5:4 of that register and odd segments use bits 1:0. Bits 7:6 and 3:2 of a nibble have no effect on routing.
- R4: Route codes are DRAM = 0, PCI = 1, DROP = 2 and OUTSIDE = 3. Attribute 3 sends reads and writes to DRAM, and attribute 0 sends both to PCI.
- R5: Attribute 1 sends reads to DRAM and writes to DROP. DROP is never given to a read.
- R6: Attribute 2 sends reads to PCI and writes to DRAM.
- R7: A request in 0xA0000–0xBFFFF goes to DRAM when control bit 6 is set, or when the request's mode flag and control bit 3 are both set. Otherwise it goes to PCI, for reads and writes alike.
- R8: The management control register is at configuration address 7. Bits 7:3 read back as last written. Bits 2:0 always read 010, and writes to them are ignored.
- R9: Configuration addresses 0–6 read back the last byte written to them.
- R10: A configuration write changes routing from the next cycle onward. A request presented in the same cycle as the write is routed under the old settings.
- R11: An address below 0xA0000 or above 0xFFFFF returns OUTSIDE (3).
- R12: With the registered variant, `rsp_valid` and `rsp_route` follow `req_valid` one cycle later, and back-to-back requests each get their own response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register select (0–6 attributes, 7 management control) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational readback of the selected register |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_smm | input | 1 | Request issued in system-management mode |
| rsp_valid | output | 1 | Route result valid |
| rsp_route | output | 2 | Route code (0 DRAM, 1 PCI, 2 DROP, 3 OUTSIDE) |

## Verification
A configuration write and a routed request can fall in the same cycle. Ordering is the hard part here, because the request must see the old attribute while the next one sees the new attribute. The bench provokes this on purpose: it issues a write to an attribute or control register together with a request to a segment that the write affects, then sends a second request to that segment in the following cycle. The scoreboard computes the expected route for each request from its register image before the write is applied. A response that reflects the new setting too early, or too late, is reported as a mismatch. A long pseudo-random phase repeats this overlap at many addresses.

// File: rtl/lmr_pkg.sv
package lmr_pkg;
   // segment geometry
   localparam int NUM_SEG   = 13;
   localparam int NUM_ATTR  = (NUM_SEG + 1) / 2;
   localparam int SMR_IDX   = NUM_ATTR;
   localparam int ATTR_W    = 8 * NUM_ATTR;
   localparam int SEG_W     = $clog2(NUM_SEG);
   localparam int RIDX_W    = $clog2(NUM_ATTR);

   // management control register fields
   localparam int          SMR_OPEN_BIT = 6;
   localparam int          SMR_GEN_BIT  = 3;
   localparam logic [2:0]  SMR_BASE_SEG = 3'b010;

   typedef enum logic [1:0] {
      RT_DRAM    = 2'd0,
      RT_PCI     = 2'd1,
      RT_DROP    = 2'd2,
      RT_OUTSIDE = 2'd3
   } route_e;

   typedef enum logic [1:0] {
      WIN_NONE  = 2'd0,
      WIN_SMRAM = 2'd1,
      WIN_SEG   = 2'd2
   } win_e;
endpackage

// File: rtl/lmr_cfg_regs.sv
module lmr_cfg_regs
   import lmr_pkg::*;
#(
   parameter int CFG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   output logic [ATTR_W-1:0] attr_flat,
   output logic              smr_open,
   output logic              smr_gen
);
   localparam int SEL_W = CFG_AW + 3;

   logic [7:3] smr_q;

   for (genvar g = 0; g < NUM_ATTR; g++) begin : g_attr
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (cfg_we && (cfg_addr == CFG_AW'(g)))
            q <= cfg_wdata;
      end
      assign attr_flat[g*8 +: 8] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         smr_q <= '0;
      else if (cfg_we && (cfg_addr == CFG_AW'(SMR_IDX)))
         smr_q <= cfg_wdata[7:3];
   end

   assign smr_open = smr_q[SMR_OPEN_BIT];
   assign smr_gen  = smr_q[SMR_GEN_BIT];

   always_comb begin
      cfg_rdata = '0;
      if (cfg_addr < CFG_AW'(NUM_ATTR))
         cfg_rdata = attr_flat[{cfg_addr, 3'b000} +: 8];
      else if (cfg_addr == CFG_AW'(SMR_IDX))
         cfg_rdata = {smr_q, SMR_BASE_SEG};
   end

   // R10: routing state moves only after a configuration write
   a_r10_state_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> ($stable(attr_flat) && $stable(smr_open) && $stable(smr_gen)));

   initial begin
      a_cfg_aw_fits: assert ((1 << CFG_AW) > SMR_IDX)
         else $fatal(1, "CFG_AW too narrow for register file");
   end

   logic unused_sel;
   assign unused_sel = ^SEL_W;
endmodule

// File: rtl/lmr_seg_decode.sv
module lmr_seg_decode
   import lmr_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-15:0] addr_blk,
   output win_e               win,
   output logic [SEG_W-1:0]   seg
);
   logic       in_meg;
   logic [5:0] blk;

   assign blk = addr_blk[5:0];

   if (ADDR_W > 20) begin : g_wide
      assign in_meg = ~|addr_blk[ADDR_W-15:6];
   end else begin : g_narrow
      assign in_meg = 1'b1;
   end

   // 16 KiB blocks: 40..47 management window, 48..59 segments 1..12, 60..63 segment 0
   always_comb begin
      win = WIN_NONE;
      seg = '0;
      if (in_meg) begin
         if (blk[5:3] == 3'b101) begin
            win = WIN_SMRAM;
         end else if (blk[5:4] == 2'b11) begin
            win = WIN_SEG;
            if (blk[3:2] != 2'b11)
               seg = SEG_W'(blk[3:0]) + SEG_W'(1);
         end
      end
   end
endmodule

// File: rtl/lmr_route_pick.sv
module lmr_route_pick
   import lmr_pkg::*;
(
   input  win_e              win,
   input  logic [SEG_W-1:0]  seg,
   input  logic              is_write,
   input  logic              is_smm,
   input  logic [ATTR_W-1:0] attr_flat,
   input  logic              smr_open,
   input  logic              smr_gen,
   output route_e            route
);
   logic [RIDX_W-1:0] ridx;
   logic [1:0]        attr;

   // register (s+1)/2; even segments use the upper nibble
   assign ridx = RIDX_W'(seg[SEG_W-1:1]) + RIDX_W'(seg[0]);
   assign attr = attr_flat[{ridx, ~seg[0], 2'b00} +: 2];

   always_comb begin
      route = RT_OUTSIDE;
      unique case (win)
         WIN_SMRAM: route = ((is_smm && smr_gen) || smr_open) ? RT_DRAM : RT_PCI;
         WIN_SEG: begin
            if (is_write)
               route = attr[1] ? RT_DRAM : (attr[0] ? RT_DROP : RT_PCI);
            else
               route = attr[0] ? RT_DRAM : RT_PCI;
         end
         default: route = RT_OUTSIDE;
      endcase
   end
endmodule

// File: rtl/lmr_router.sv
module lmr_router
   import lmr_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int CFG_AW  = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic              req_smm,
   output logic              rsp_valid,
   output logic [1:0]        rsp_route
);
   logic [ATTR_W-1:0] attr_flat;
   logic              smr_open;
   logic              smr_gen;
   win_e              win;
   logic [SEG_W-1:0]  seg;
   route_e            route_now;

   initial begin
      a_addr_w_min: assert (ADDR_W >= 20)
         else $fatal(1, "ADDR_W must cover the first megabyte");
   end

   lmr_cfg_regs #(.CFG_AW(CFG_AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .attr_flat (attr_flat),
      .smr_open  (smr_open),
      .smr_gen   (smr_gen)
   );

   lmr_seg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr_blk (req_addr[ADDR_W-1:14]),
      .win      (win),
      .seg      (seg)
   );

   lmr_route_pick u_pick (
      .win       (win),
      .seg       (seg),
      .is_write  (req_write),
      .is_smm    (req_smm),
      .attr_flat (attr_flat),
      .smr_open  (smr_open),
      .smr_gen   (smr_gen),
      .route     (route_now)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_route <= RT_OUTSIDE;
         end else begin
            rsp_valid <= req_valid;
            if (req_valid)
               rsp_route <= route_now;
         end
      end

      // R12: one response per request, one cycle later
      a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid == $past(req_valid));

      // R11: below the window is never decoded
      a_r11_low_outside: assert property (@(posedge clk) disable iff (!rst_n)
         $past(req_valid && (req_addr < ADDR_W'(32'hA0000))) |-> (rsp_route == RT_OUTSIDE));

      // R5: a read is never dropped
      a_r5_drop_is_write: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && (rsp_route == RT_DROP)) |-> $past(req_write));
   end else begin : g_comb
      assign rsp_valid = req_valid;
      assign rsp_route = route_now;
   end
endmodule

// File: tb/lmr_router_tb.sv
module lmr_router_tb;
   localparam int ADDR_W = 32;
   localparam int CFG_AW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [CFG_AW-1:0] cfg_addr = '0;
   logic [7:0]        cfg_wdata = '0;
   logic [7:0]        cfg_rdata;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_write = 1'b0;
   logic              req_smm = 1'b0;
   logic              rsp_valid;
   logic [1:0]        rsp_route;

   int vectors = 0;
   int miscompares = 0;

   logic [7:0] m_attr [7];
   logic [7:0] m_smr;

   logic [1:0] exp_q [$];
   string      tag_q [$];

   always #4 clk = ~clk;

   lmr_router #(.ADDR_W(ADDR_W), .CFG_AW(CFG_AW), .REG_OUT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .req_write(req_write), .req_smm(req_smm),
      .rsp_valid(rsp_valid), .rsp_route(rsp_route));

   function automatic logic [1:0] model_route(logic [31:0] a, logic wr, logic smm);
      int s;
      logic [7:0] b;
      logic [1:0] at;
      if (a < 32'hA0000 || a > 32'hFFFFF) return 2'd3;           // R11
      if (a < 32'hC0000)                                          // R7
         return ((smm && m_smr[3]) || m_smr[6]) ? 2'd0 : 2'd1;
      s  = (a >= 32'hF0000) ? 0 : int'((a - 32'hC0000) >> 14) + 1; // R2
      b  = m_attr[(s + 1) / 2];                                    // R3
      at = (s % 2 == 1) ? b[1:0] : b[5:4];
      case (at)
         2'd3: return 2'd0;                                        // R4
         2'd0: return 2'd1;
         2'd1: return wr ? 2'd2 : 2'd0;                            // R5
         default: return wr ? 2'd0 : 2'd1;                         // R6
      endcase
   endfunction

   // one cycle of stimulus: optional request and optional config write together
   task automatic step(input bit doreq, input logic [31:0] a, input logic wr,
                       input logic smm, input string tag,
                       input bit docfg, input logic [2:0] ca, input logic [7:0] cd);
      @(posedge clk);
      #1;
      req_valid = doreq;
      req_addr  = a;
      req_write = wr;
      req_smm   = smm;
      cfg_we    = docfg;
      cfg_addr  = ca;
      cfg_wdata = cd;
      if (doreq) begin
         exp_q.push_back(model_route(a, wr, smm));
         tag_q.push_back(tag);
      end
      if (docfg) begin
         if (ca < 3'd7) m_attr[ca] = cd;
         else           m_smr = {cd[7:3], 3'b010};
      end
   endtask

   task automatic req(input logic [31:0] a, input logic wr, input logic smm, input string tag);
      step(1'b1, a, wr, smm, tag, 1'b0, 3'd0, 8'd0);
   endtask

   task automatic wcfg(input logic [2:0] ca, input logic [7:0] cd);
      step(1'b0, 32'd0, 1'b0, 1'b0, "", 1'b1, ca, cd);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 32'd0, 1'b0, 1'b0, "", 1'b0, 3'd0, 8'd0);
   endtask

   task automatic rd_check(input logic [2:0] ca, input logic [7:0] exp, input string tag);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      cfg_we    = 1'b0;
      cfg_addr  = ca;
      #2;
      vectors++;
      if (cfg_rdata !== exp) begin
         miscompares++;
         $display("FAIL %s readback addr %0d actual 0x%02h expected 0x%02h", tag, ca, cfg_rdata, exp);
      end
   endtask

   // monitor: pop an expected route for every response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         vectors++;
         if (exp_q.size() == 0) begin
            miscompares++;
            $display("FAIL R12 unexpected response actual %0d expected none", rsp_route);
         end else begin
            automatic logic [1:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            if (rsp_route !== e) begin
               miscompares++;
               $display("FAIL %s route actual %0d expected %0d", t, rsp_route, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL R12 watchdog expired actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      for (int i = 0; i < 7; i++) m_attr[i] = 8'h00;
      m_smr = 8'h02;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      #2;
      vectors++;
      if (rsp_valid !== 1'b0) begin
         miscompares++;
         $display("FAIL R1 rsp_valid actual %0b expected 0", rsp_valid);
      end
      for (int i = 0; i < 7; i++) rd_check(3'(i), 8'h00, "R1");
      rd_check(3'd7, 8'h02, "R1");
      for (int s = 0; s < 13; s++) begin
         automatic logic [31:0] a = (s == 0) ? 32'hF8000 : 32'hC0000 + 32'(s - 1) * 32'h4000;
         req(a, 1'b0, 1'b0, "R1");
         req(a, 1'b1, 1'b1, "R1");
      end
      req(32'hA0000, 1'b0, 1'b1, "R1");
      req(32'hBFFFF, 1'b1, 1'b1, "R1");

      // R3 R9: program attributes, junk in unused nibble bits
      wcfg(3'd0, 8'hF7);
      wcfg(3'd1, 8'h12);
      wcfg(3'd2, 8'h3C);
      wcfg(3'd3, 8'h2D);
      wcfg(3'd4, 8'h01);
      wcfg(3'd5, 8'hE3);
      wcfg(3'd6, 8'h9B);
      rd_check(3'd0, 8'hF7, "R9");
      rd_check(3'd3, 8'h2D, "R9");
      rd_check(3'd6, 8'h9B, "R9");

      // R2 R4 R5 R6: both ends of every segment, read and write (back-to-back, R12)
      for (int s = 0; s < 13; s++) begin
         automatic logic [31:0] lo = (s == 0) ? 32'hF0000 : 32'hC0000 + 32'(s - 1) * 32'h4000;
         automatic logic [31:0] hi = (s == 0) ? 32'hFFFFF : lo + 32'h3FFF;
         req(lo, 1'b0, 1'b0, "R2");
         req(lo, 1'b1, 1'b0, "R4");
         req(hi, 1'b0, 1'b1, "R5");
         req(hi, 1'b1, 1'b1, "R6");
      end

      // R8: base bits fixed
      wcfg(3'd7, 8'hFF);
      rd_check(3'd7, 8'hFA, "R8");
      wcfg(3'd7, 8'h05);
      rd_check(3'd7, 8'h02, "R8");

      // R7: management window visibility
      wcfg(3'd7, 8'h08);
      req(32'hA0000, 1'b0, 1'b0, "R7");
      req(32'hA0000, 1'b0, 1'b1, "R7");
      req(32'hBFFFF, 1'b1, 1'b1, "R7");
      wcfg(3'd7, 8'h40);
      req(32'hB0000, 1'b0, 1'b0, "R7");
      req(32'hB0000, 1'b1, 1'b0, "R7");
      wcfg(3'd7, 8'h30);
      req(32'hA4000, 1'b0, 1'b1, "R7");

      // R11: outside window
      req(32'h0009FFFF, 1'b0, 1'b0, "R11");
      req(32'h00000000, 1'b1, 1'b0, "R11");
      req(32'h00100000, 1'b0, 1'b1, "R11");
      req(32'hFFFFFFFF, 1'b1, 1'b0, "R11");
      req(32'h000F0000 | 32'h80000000, 1'b0, 1'b0, "R11");

      // R10: write and request in the same cycle, then the next cycle
      step(1'b1, 32'hC4000, 1'b1, 1'b0, "R10", 1'b1, 3'd1, 8'h30);
      req(32'hC4000, 1'b1, 1'b0, "R10");
      step(1'b1, 32'hF0000, 1'b0, 1'b0, "R10", 1'b1, 3'd0, 8'h00);
      req(32'hF0000, 1'b0, 1'b0, "R10");
      step(1'b1, 32'hA8000, 1'b0, 1'b0, "R10", 1'b1, 3'd7, 8'h40);
      req(32'hA8000, 1'b0, 1'b0, "R10");

      // mixed overlap phase
      lfsr = 32'h1ACE_5EED;
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         step(1'b1, {12'h000, lfsr[19:0] | 20'h80000}, lfsr[24], lfsr[25], "R10",
              (i % 5) == 0, lfsr[28:26], lfsr[7:0] ^ lfsr[31:24]);
      end

      idle(4);
      vectors++;
      if (exp_q.size() != 0) begin
         miscompares++;
         $display("FAIL R12 pending responses actual %0d expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule